// File: doc/BRIEF.md
# Calibrated 20-bit output code generator

This block turns a signed 24-bit raw measurement, delivered by an upstream filter, into a 20-bit output code. The code is scaled against two stored calibration values: a zero point and a span that runs from the zero point to the full-scale point. A controller loads these values through a strobe-driven calibration port. Writing a new zero point leaves the span as it is, so a later offset-only recalibration moves the whole transfer function without changing its gain. Writing a full-scale reading sets the span to that reading minus the current zero point.

Each accepted sample is divided by the span in a bit-serial restoring divider. The code appears with a one-cycle valid pulse a fixed 48 cycles after acceptance. The coding mode is chosen per sample. In unipolar mode the code is straight binary, with the zero point at 00000. In bipolar mode the code is offset binary, centred on the zero point at 80000, and each step is worth twice as much input. Results are rounded to the nearest code and clamped at both ends. A span that is zero or negative makes the result 00000 and raises an error flag.

Top module: `cal_code_gen`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, out_code is 00000 and out_err is 0. The zero point is 0 and the span is 2^20, so a unipolar result equals the raw value until it saturates.
- R2: A sample is accepted on a rising edge where in_valid and in_ready are both 1. From the next cycle in_ready is 0. Exactly 48 rising edges after acceptance, out_valid is 1 for one cycle and in_ready returns to 1 in that same cycle.
- R3: in_valid asserted while in_ready is 0 is ignored. It produces no extra result and does not change the pending result.
- R4: cal_stb with cal_full=1 sets the span to cal_val minus the stored zero point, with both treated as signed 24-bit values.
- R5: cal_stb with cal_full=0 replaces the zero point with cal_val and keeps the stored span unchanged.
- R6: In unipolar mode (bipolar=0), the code is round((raw − zero) · 2^20 / span).
- R7: In bipolar mode (bipolar=1), the code is 80000h + round((raw − zero) · 2^19 / span). A raw value equal to the zero point gives 80000, and a raw value half a step below it is the 7FFFF/80000 transition.
- R8: Rounding is to the nearest code, and an exact half-step goes to the higher code.
- R9: Results below 00000 are output as 00000, and results above FFFFF are output as FFFFF.
- R10: If the span is zero or negative when a sample is accepted, out_code is 00000 and out_err is 1 with that result. Otherwise out_err is 0.
- R11: The bipolar input is sampled at acceptance. Changing it while a conversion is in flight has no effect on that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bipolar | input | 1 | Coding mode for the sample being accepted: 1 selects offset binary |
| cal_stb | input | 1 | One-cycle strobe that loads a calibration value |
| cal_full | input | 1 | 1: cal_val is a full-scale reading; 0: cal_val is a new zero point |
| cal_val | input | 24 | Signed calibration reading |
| in_valid | input | 1 | Raw sample valid |
| in_ready | output | 1 | High when a new sample can be taken |
| in_raw | input | 24 | Signed raw sample |
| out_valid | output | 1 | One-cycle result pulse |
| out_code | output | 20 | Output code, held until the next result |
| out_err | output | 1 | Span was not positive for this result |

## Verification
The hardest cases to reach are the exact half-code ties and the edges of the clamping, because both depend on how raw value, zero point and span combine. The bench reaches ties in bipolar mode at the reset span, where one raw step is half a code, so raw values of ±1 and −3 land on transition points. It reaches both saturation limits with raw values just past ±2^20. Spans of zero and negative spans are produced by writing a full-scale reading at or below the zero point. Every conversion also drives a refused sample and flips the mode pin mid-flight, so R3 and R11 are checked on every result.

// File: rtl/cal_code_gen.sv
module cal_code_gen #(
  parameter int RAW_W  = 24,
  parameter int CODE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bipolar,
  input  logic              cal_stb,
  input  logic              cal_full,
  input  logic [RAW_W-1:0]  cal_val,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RAW_W-1:0]  in_raw,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic              out_err
);
  localparam int SPAN_W = RAW_W + 1;
  localparam int DV_W   = RAW_W + CODE_W + 4;
  localparam int MAG_W  = DV_W - 1;
  localparam int DS_W   = SPAN_W + 1;
  localparam int CNT_W  = $clog2(MAG_W + 1);
  localparam logic signed [DV_W:0] HALF = (DV_W+1)'(1) <<< (CODE_W - 1);
  localparam logic signed [DV_W:0] MAXC = ((DV_W+1)'(1) <<< CODE_W) - 1;

  logic signed [RAW_W-1:0]  zero_q;
  logic signed [SPAN_W-1:0] span_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_q <= '0;
      span_q <= SPAN_W'(1) <<< CODE_W;
    end else if (cal_stb) begin
      if (cal_full) span_q <= $signed({cal_val[RAW_W-1], cal_val}) - $signed({zero_q[RAW_W-1], zero_q});
      else          zero_q <= cal_val;
    end
  end

  logic signed [SPAN_W-1:0] diff;
  logic signed [DV_W-1:0]   dext, num;
  logic [MAG_W-1:0]         mag;
  logic                     span_bad, take;

  assign take     = in_valid && in_ready;
  assign diff     = $signed({in_raw[RAW_W-1], in_raw}) - $signed({zero_q[RAW_W-1], zero_q});
  assign dext     = {{(DV_W-SPAN_W){diff[SPAN_W-1]}}, diff};
  assign num      = (bipolar ? (dext <<< CODE_W) : (dext <<< (CODE_W + 1)))
                  + {{(DV_W-SPAN_W){span_q[SPAN_W-1]}}, span_q};
  assign mag      = MAG_W'(num[DV_W-1] ? -num : num);
  assign span_bad = span_q[SPAN_W-1] || (span_q == '0);

  logic              busy, neg_q, bip_q, err_q;
  logic [CNT_W-1:0]  cnt;
  logic [DS_W-1:0]   rem_q, dvs_q;
  logic [MAG_W-1:0]  quo_q;
  logic [DS_W:0]     tmp, sub;

  assign in_ready = !busy;
  assign tmp      = {rem_q, quo_q[MAG_W-1]};
  assign sub      = tmp - {1'b0, dvs_q};

  logic signed [DV_W:0] qv, cv;
  always_comb begin
    qv = $signed({2'b00, quo_q});
    if (neg_q) qv = -(qv + (DV_W+1)'(rem_q != '0));
    cv = qv + (bip_q ? HALF : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      rem_q     <= '0;
      dvs_q     <= '0;
      quo_q     <= '0;
      neg_q     <= 1'b0;
      bip_q     <= 1'b0;
      err_q     <= 1'b0;
      out_valid <= 1'b0;
      out_code  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (take) begin
        busy  <= 1'b1;
        cnt   <= CNT_W'(MAG_W);
        rem_q <= '0;
        quo_q <= mag;
        dvs_q <= {span_q, 1'b0};
        neg_q <= num[DV_W-1];
        bip_q <= bipolar;
        err_q <= span_bad;
      end else if (busy) begin
        if (cnt != '0) begin
          cnt   <= cnt - 1'b1;
          rem_q <= sub[DS_W] ? tmp[DS_W-1:0] : sub[DS_W-1:0];
          quo_q <= {quo_q[MAG_W-2:0], !sub[DS_W]};
        end else begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_err   <= err_q;
          if (err_q || cv < 0) out_code <= '0;
          else if (cv > MAXC)  out_code <= '1;
          else                 out_code <= cv[CODE_W-1:0];
        end
      end
    end
  end

  // R2: one-cycle result pulse, and ready comes back with it
  a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid);
  a_r2_ready_at_result: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> in_ready);
  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !in_ready);
  // R3: a result only ends a busy period
  a_r3_result_from_busy: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_valid) |-> $past(!in_ready));
  // R5: a zero-point write leaves the span alone
  a_r5_span_kept: assert property (@(posedge clk) disable iff (!rst_n) (cal_stb && !cal_full) |=> $stable(span_q));
  // R10: an error result carries code zero
  a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_err) |-> (out_code == '0));
endmodule

// File: tb/cal_code_gen_tb.sv
module cal_code_gen_tb;
  localparam int RAW_W  = 24;
  localparam int CODE_W = 20;
  localparam int LAT    = RAW_W + CODE_W + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bipolar = 1'b0, cal_stb = 1'b0, cal_full = 1'b0, in_valid = 1'b0;
  logic [RAW_W-1:0] cal_val = '0, in_raw = '0;
  logic in_ready, out_valid, out_err;
  logic [CODE_W-1:0] out_code;

  int checks = 0, fails = 0;
  bit finished = 0;
  longint zero_m = 0, span_m = 1 << 20;

  always #4 clk = ~clk;

  cal_code_gen #(.RAW_W(RAW_W), .CODE_W(CODE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bipolar(bipolar), .cal_stb(cal_stb), .cal_full(cal_full),
    .cal_val(cal_val), .in_valid(in_valid), .in_ready(in_ready), .in_raw(in_raw),
    .out_valid(out_valid), .out_code(out_code), .out_err(out_err));

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic longint floor_div(input longint a, input longint b);
    longint q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  function automatic longint model_code(input longint raw, input bit bip, output bit err);
    longint s, q, lim;
    err = 0;
    if (span_m <= 0) begin err = 1; return 0; end
    s   = bip ? 19 : 20;
    q   = floor_div((raw - zero_m) * (longint'(1) << (s + 1)) + span_m, 2 * span_m);
    if (bip) q = q + (1 << 19);
    lim = (1 << 20) - 1;
    if (q < 0) q = 0;
    if (q > lim) q = lim;
    return q;
  endfunction

  task automatic calib(input bit full, input longint val);
    @(negedge clk);
    cal_stb = 1'b1; cal_full = full; cal_val = RAW_W'(val);
    @(negedge clk);
    cal_stb = 1'b0;
    if (full) span_m = val - zero_m;
    else      zero_m = val;
  endtask

  task automatic convert(input string req, input longint raw, input bit bip);
    longint exp_code;
    bit exp_err;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    exp_code = model_code(raw, bip, exp_err);
    in_raw = RAW_W'(raw); bipolar = bip; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 1; k <= LAT; k++) begin
      check("R2", "out_valid while busy", out_valid, 0);
      check("R2", "in_ready while busy", in_ready, 0);
      if (k == 2) begin in_valid = 1'b1; in_raw = RAW_W'(raw + 77); end
      if (k == 3) in_valid = 1'b0;
      if (k == 5) bipolar = !bip;
      @(negedge clk);
    end
    check("R2", "out_valid at latency", out_valid, 1);
    check("R2", "in_ready at result", in_ready, 1);
    check(req, "out_code", out_code, exp_code);
    check("R10", "out_err", out_err, exp_err);
    check("R11", "out_code with mode flipped in flight", out_code, exp_code);
    bipolar = bip;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "in_ready", in_ready, 1);
    check("R1", "out_valid", out_valid, 0);
    check("R1", "out_code", out_code, 0);
    check("R1", "out_err", out_err, 0);
    rst_n = 1'b1;
    convert("R1", 1234, 0);
    convert("R6", 0, 0);
    convert("R9", -5, 0);
    convert("R9", 1 << 20, 0);
    convert("R6", (1 << 20) - 1, 0);
    convert("R9", 8388607, 0);
    convert("R7", 0, 1);
    convert("R8", 1, 1);
    convert("R8", -1, 1);
    convert("R8", -3, 1);
    convert("R9", 1 << 20, 1);
    convert("R9", -(1 << 20) - 2, 1);
    convert("R9", -8388608, 1);
    calib(0, 100);
    convert("R5", 1334, 0);
    calib(1, 1100);
    convert("R4", 600, 0);
    convert("R6", 101, 0);
    convert("R6", 100, 0);
    convert("R7", 100, 1);
    convert("R7", 99, 1);
    calib(0, -50);
    convert("R5", 450, 0);
    calib(1, -50);
    convert("R10", 300, 0);
    calib(1, -1000);
    convert("R10", -2000, 1);
    calib(1, 999950);
    convert("R4", 499950, 0);
    convert("R7", -500050, 1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R3", "no stray result when idle", out_valid, 0);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule